// File: doc/BRIEF.md
# Register-Mapped Adder with Clock Output Select

This block is a small slave on a simple 32-bit memory-mapped bus. Software writes two operand registers and reads back their sum from a third address. A fourth register holds a one-bit selector that steers either the bus clock or a reference clock onto a single clock output pin. The selector is typically used to pick a bus-rate or reference-rate clock for observation or for driving an external circuit.

Each bus access takes one cycle. Writes land at the rising edge on which `wr_en` is sampled. Reads are registered: the word for the address presented with `rd_en` appears on `rd_data` after that edge, and it stays there until the next read.

Top module: `adder_clk_regs`

## Requirements
- R1: After reset, both operands read as zero, the select bit is zero, and `rd_data` is zero.
- R2: A write to byte offset 0x0 stores the full 32-bit word as operand A. A write to offset 0x4 stores it as operand B. A read of either offset returns the stored word.
- R3: A read of offset 0x8 returns (A + B) mod 2^32, and the carry out is discarded.
- R4: A write to offset 0x8 changes neither operand nor the select bit.
- R5: A write to offset 0xC stores only bit 0 of the write data as the select bit. A read of 0xC returns the select bit in bit 0, with bits 31..1 zero.
- R6: `clk_out` follows `bus_clk_in` while the select bit is 0 and follows `ref_clk_in` while it is 1.
- R7: A read of any other offset, including one with address bits 1..0 nonzero, returns zero. A write to such an offset changes no register.
- R8: `rd_data` updates on the clock edge at which `rd_en` is sampled. A read issued in the cycle right after a write returns a value that already includes that write.
- R9: `rd_data` keeps its value in every cycle in which `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock for all registers |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Byte address of the access |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_data | output | 32 | Registered read data |
| bus_clk_in | input | 1 | Bus-rate clock source for the output mux |
| ref_clk_in | input | 1 | Reference clock source for the output mux |
| clk_out | output | 1 | Selected clock |

## Verification
A corrupted operand register shows up in the first read of its own offset and also in every later sum read, so a sum mismatch with a correct operand readback isolates a fault to the adder. Because reads are registered, a decoding or storage error reaches `rd_data` exactly one edge after the read strobe. A wrong select bit shows up at once on `clk_out` as the wrong clock source, and on the next read of 0xC as the wrong bit 0.

// File: rtl/adder_clk_regs.sv
module adder_clk_regs #(
  parameter int ADDR_W = 8,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  output logic [DW-1:0]     rd_data,
  input  logic              bus_clk_in,
  input  logic              ref_clk_in,
  output logic              clk_out
);

  localparam logic [ADDR_W-1:0] OFF_A   = ADDR_W'('h0);
  localparam logic [ADDR_W-1:0] OFF_B   = ADDR_W'('h4);
  localparam logic [ADDR_W-1:0] OFF_SUM = ADDR_W'('h8);
  localparam logic [ADDR_W-1:0] OFF_SEL = ADDR_W'('hC);

  logic [DW-1:0] op_a, op_b, sum, rd_word;
  logic          sel;

  assign sum     = op_a + op_b;
  assign clk_out = sel ? ref_clk_in : bus_clk_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_a <= '0;
      op_b <= '0;
      sel  <= 1'b0;
    end else if (wr_en) begin
      if (addr == OFF_A)   op_a <= wr_data;
      if (addr == OFF_B)   op_b <= wr_data;
      if (addr == OFF_SEL) sel  <= wr_data[0];
    end
  end

  always_comb begin
    case (addr)
      OFF_A:   rd_word = op_a;
      OFF_B:   rd_word = op_b;
      OFF_SUM: rd_word = sum;
      OFF_SEL: rd_word = {{(DW-1){1'b0}}, sel};
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_word;
  end

  // Requirement R2
  a_r2_store_a: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == OFF_A |=> op_a == $past(wr_data));

  // Requirement R4
  a_r4_sum_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == OFF_SUM |=> $stable(op_a) && $stable(op_b) && $stable(sel));

  // Requirement R5
  a_r5_sel_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == OFF_SEL |=> rd_data[DW-1:1] == '0);

  // Requirement R7
  a_r7_undecoded_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr != OFF_A && addr != OFF_B && addr != OFF_SUM && addr != OFF_SEL
    |=> rd_data == '0);

  // Requirement R9
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

endmodule

// File: tb/adder_clk_regs_tb.sv
module adder_clk_regs_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  addr = '0;
  logic        wr_en = 0, rd_en = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        bus_clk_in = 0, ref_clk_in = 0;
  logic        clk_out;

  int errors = 0, checks = 0;
  logic [31:0] m_a = 0, m_b = 0;
  logic        m_sel = 0;

  adder_clk_regs u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .bus_clk_in(bus_clk_in),
    .ref_clk_in(ref_clk_in), .clk_out(clk_out)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h00: return m_a;
      8'h04: return m_b;
      8'h08: return m_a + m_b;
      8'h0C: return {31'b0, m_sel};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    case (a)
      8'h00: m_a = d;
      8'h04: m_b = d;
      8'h0C: m_sel = d[0];
      default: ;
    endcase
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1;
    @(posedge clk);
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic read_check(input string req, input logic [7:0] a);
    logic [31:0] d;
    bus_read(a, d);
    check(req, d, exp_read(a));
  endtask

  task automatic clk_check(input string req);
    bus_clk_in = 1; ref_clk_in = 0; #1;
    check(req, {31'b0, clk_out}, {31'b0, ~m_sel});
    bus_clk_in = 0; ref_clk_in = 1; #1;
    check(req, {31'b0, clk_out}, {31'b0, m_sel});
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d, held;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1 check("R1 rd_data reset", rd_data, 32'h0);
    read_check("R1 op A reset", 8'h00);
    read_check("R1 op B reset", 8'h04);
    read_check("R1 sel reset", 8'h0C);
    clk_check("R1 R6 clk_out reset");

    bus_write(8'h00, 32'h1234_5678);
    read_check("R2 op A", 8'h00);
    bus_write(8'h04, 32'h0000_1111);
    read_check("R2 op B", 8'h04);
    read_check("R3 sum", 8'h08);
    read_check("R8 sum after write", 8'h08);

    bus_write(8'h00, 32'hFFFF_FFFF);
    bus_write(8'h04, 32'h0000_0002);
    read_check("R3 wrap", 8'h08);

    bus_write(8'h08, 32'hDEAD_BEEF);
    read_check("R4 op A after sum write", 8'h00);
    read_check("R4 op B after sum write", 8'h04);
    read_check("R4 sum after sum write", 8'h08);

    bus_write(8'h0C, 32'hFFFF_FFFF);
    read_check("R5 sel set", 8'h0C);
    clk_check("R6 ref selected");
    bus_write(8'h0C, 32'hFFFF_FFFE);
    read_check("R5 sel clear", 8'h0C);
    clk_check("R6 bus selected");

    bus_write(8'h10, 32'hAAAA_5555);
    bus_write(8'h01, 32'h5555_AAAA);
    read_check("R7 undecoded 0x10", 8'h10);
    read_check("R7 misaligned 0x01", 8'h01);
    read_check("R7 op A intact", 8'h00);
    read_check("R7 op B intact", 8'h04);

    bus_read(8'h00, held);
    @(negedge clk) addr = 8'h08;
    repeat (3) @(negedge clk);
    check("R9 hold", rd_data, held);

    // R8: read in the cycle right after a write
    @(negedge clk); addr = 8'h00; wr_data = 32'h0BAD_F00D; wr_en = 1;
    @(negedge clk); wr_en = 0; m_a = 32'h0BAD_F00D; addr = 8'h08; rd_en = 1;
    @(posedge clk); #1 check("R8 back-to-back", rd_data, m_a + m_b);
    @(negedge clk) rd_en = 0;

    for (int i = 0; i < 300; i++) begin
      logic [7:0] a;
      case ($urandom % 6)
        0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08; 3: a = 8'h0C;
        4: a = 8'($urandom % 64); default: a = 8'h08;
      endcase
      if ($urandom % 2) bus_write(a, $urandom);
      else read_check("R3 R7 random", a);
      if (i % 50 == 0) clk_check("R6 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule